// File: doc/BRIEF.md
# E1 Loopback Routing Matrix

This block sits between the system-side serial interface and the line-side PCM30 path of an E1 port and chooses where each time-slot byte goes. In normal service, bytes from the system input are sent to the line transmit path, and bytes received from the line are sent to the system output. For maintenance it offers four whole-stream loopbacks, selected by a four-bit control register. It also offers two per-slot loopbacks, selected by a two-bit field in a 32-entry per-slot control table.

Both streams carry one byte per valid cycle together with its slot index. The two streams need not be aligned. The block keeps the most recent byte of every slot from each stream, so that a per-slot loopback can place the other direction's byte into its own slot. While the payload loopback is active, slot 0 of the transmit stream is rebuilt at the loop point. It alternates between the frame alignment word and the non-alignment word, and the non-alignment word carries idle data-link bits.

Top module: `e1_loopback_matrix`

## Requirements
- R1: After reset, both output valids are 0, the output data and slot are 0, and no loopback is active.
- R2: With no loopback active, each valid system input byte appears on the line transmit output, and each valid received byte appears on the system output. Each keeps its slot and arrives one clock later. An output is never valid unless its source stream was valid in the previous cycle.
- R3: The global control word is written with `ctl_wr`, and its bits have these meanings: bit 3 digital, bit 2 remote, bit 1 system-bus, bit 0 payload. A write takes effect for stream bytes presented in the next cycle.
- R4: Remote loopback copies the received stream, slot 0 included, unchanged onto line transmit. The system output keeps receiving the line data.
- R5: Payload loopback copies received slots 1 to 31 onto line transmit. Slot 0 is replaced by 0x9B and 0xDF in turn, and 0x9B comes first after the mode is entered. The system output keeps receiving the line data.
- R6: Digital loopback sends to the system output the same stream that goes to line transmit (the system input after per-slot local substitution). Line transmit still carries it.
- R7: System-bus loopback sends the system input unchanged to the system output, with no per-slot substitution. Line transmit stays in normal service.
- R8: When several global bits are set, exactly one loopback acts, chosen in this order: remote, payload, digital, system-bus.
- R9: Per-slot word bit 4 (remote slot loop) makes slot k of the system output carry the latest system input byte of slot k. Bit 5 (local slot loop) makes slot k of line transmit carry the latest received byte of slot k. A new per-slot word is written with `slot_wr`.
- R10: The local slot loop has no effect while remote or payload loopback is active. The remote slot loop has no effect while digital or system-bus loopback is active.
- R11: Slot 0 is never changed by the per-slot bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the global loopback word |
| ctl_wdata | input | 4 | Global loopback word (bit 3 digital, 2 remote, 1 bus, 0 payload) |
| slot_wr | input | 1 | Write strobe for one per-slot control word |
| slot_wr_idx | input | 5 | Slot addressed by the write |
| slot_wr_bits | input | 2 | Per-slot word bits [5:4]: bit 5 local, bit 4 remote |
| sys_in_vld | input | 1 | System input byte valid |
| sys_in_slot | input | 5 | System input slot index |
| sys_in_data | input | 8 | System input byte |
| line_rx_vld | input | 1 | Received line byte valid |
| line_rx_slot | input | 5 | Received slot index |
| line_rx_data | input | 8 | Received line byte |
| line_tx_vld | output | 1 | Line transmit byte valid |
| line_tx_slot | output | 5 | Line transmit slot index |
| line_tx_data | output | 8 | Line transmit byte |
| sys_out_vld | output | 1 | System output byte valid |
| sys_out_slot | output | 5 | System output slot index |
| sys_out_data | output | 8 | System output byte |

## Verification
Each mode is driven with three kinds of byte: system bytes and line bytes that carry different values in the same slot, slot 0 bytes, and bytes in slots that have a per-slot bit set. Together these show which stream each output follows, and whether a stored byte or a live byte was chosen. The stored bytes are preloaded with values that differ from the live bytes in the same cycle, so a per-slot loopback that is wrongly obeyed or wrongly ignored shows up in the output. Several global bits are set at once, and the winner is chosen so that each priority pair gives a visibly different output. Slot 0 is repeated in payload mode to check the alternation of the two frame words.

// File: rtl/e1lb_pkg.sv
package e1lb_pkg;
  localparam int BYTE_W = 8;
  localparam int GLB_W  = 4;

  // global word bit positions
  localparam int GB_PAYLOAD = 0;
  localparam int GB_BUS     = 1;
  localparam int GB_REMOTE  = 2;
  localparam int GB_DIGITAL = 3;

  // per-slot word bit positions
  localparam int SB_REMOTE_TS = 4;
  localparam int SB_LOCAL_TS  = 5;

  typedef enum logic [2:0] {
    LB_NONE    = 3'd0,
    LB_REMOTE  = 3'd1,
    LB_PAYLOAD = 3'd2,
    LB_DIGITAL = 3'd3,
    LB_BUS     = 3'd4
  } lb_mode_e;

  function automatic lb_mode_e pick_mode(input logic [GLB_W-1:0] g);
    if (g[GB_REMOTE])       return LB_REMOTE;
    else if (g[GB_PAYLOAD]) return LB_PAYLOAD;
    else if (g[GB_DIGITAL]) return LB_DIGITAL;
    else if (g[GB_BUS])     return LB_BUS;
    else                    return LB_NONE;
  endfunction

  function automatic logic owns_line(input lb_mode_e m);
    return (m == LB_REMOTE) || (m == LB_PAYLOAD);
  endfunction

  function automatic logic owns_sys(input lb_mode_e m);
    return (m == LB_DIGITAL) || (m == LB_BUS);
  endfunction

  function automatic logic [BYTE_W-1:0] frame_word(input logic odd,
                                                   input logic [BYTE_W-1:0] fas,
                                                   input logic [BYTE_W-1:0] nfas);
    return odd ? nfas : fas;
  endfunction
endpackage

// File: rtl/e1lb_cfg.sv
module e1lb_cfg
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  localparam int NSLOTS = 1 << SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_wr,
  input  logic [GLB_W-1:0]       ctl_wdata,
  input  logic                   slot_wr,
  input  logic [SLOT_W-1:0]      slot_wr_idx,
  input  logic [SB_LOCAL_TS:SB_REMOTE_TS] slot_wr_bits,
  output lb_mode_e               mode,
  output logic [NSLOTS-1:0]      rem_ts,
  output logic [NSLOTS-1:0]      loc_ts
);
  logic [GLB_W-1:0] glb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= '0;
    else if (ctl_wr) glb_q <= ctl_wdata;
  end

  assign mode = pick_mode(glb_q);

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_ts[s] <= 1'b0;
        loc_ts[s] <= 1'b0;
      end else if (slot_wr && (slot_wr_idx == SLOT_W'(s))) begin
        rem_ts[s] <= slot_wr_bits[SB_REMOTE_TS];
        loc_ts[s] <= slot_wr_bits[SB_LOCAL_TS];
      end
    end
  end
endmodule

// File: rtl/e1lb_store.sv
module e1lb_store
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  localparam int NSLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem_q [NSLOTS];

  for (genvar s = 0; s < NSLOTS; s++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     mem_q[s] <= '0;
      else if (wr_en && (wr_idx == SLOT_W'(s)))       mem_q[s] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/e1lb_line_side.sv
module e1lb_line_side
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter logic [BYTE_W-1:0] FAS_WORD  = 8'h9B,
  parameter logic [BYTE_W-1:0] NFAS_WORD = 8'hDF,
  localparam int NSLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lb_mode_e          mode,
  input  logic [NSLOTS-1:0] loc_ts,
  input  logic              sys_in_vld,
  input  logic [SLOT_W-1:0] sys_in_slot,
  input  logic [BYTE_W-1:0] sys_in_data,
  input  logic              line_rx_vld,
  input  logic [SLOT_W-1:0] line_rx_slot,
  input  logic [BYTE_W-1:0] line_rx_data,
  input  logic [BYTE_W-1:0] rx_store_rd,
  output logic              nxt_vld,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BYTE_W-1:0] nxt_data,
  output logic              fas_odd,
  output logic              tx_vld,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [BYTE_W-1:0] tx_data
);
  logic loc_hit;
  assign loc_hit = loc_ts[sys_in_slot] && (sys_in_slot != '0);

  always_comb begin
    nxt_vld  = sys_in_vld;
    nxt_slot = sys_in_slot;
    nxt_data = sys_in_data;
    if (owns_line(mode)) begin
      nxt_vld  = line_rx_vld;
      nxt_slot = line_rx_slot;
      nxt_data = line_rx_data;
      if ((mode == LB_PAYLOAD) && (line_rx_slot == '0))
        nxt_data = frame_word(fas_odd, FAS_WORD, NFAS_WORD);
    end else if (loc_hit) begin
      nxt_data = rx_store_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                fas_odd <= 1'b0;
    else if (mode != LB_PAYLOAD)               fas_odd <= 1'b0;
    else if (nxt_vld && (nxt_slot == '0))      fas_odd <= ~fas_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_vld  <= 1'b0;
      tx_slot <= '0;
      tx_data <= '0;
    end else begin
      tx_vld  <= nxt_vld;
      tx_slot <= nxt_slot;
      tx_data <= nxt_data;
    end
  end
endmodule

// File: rtl/e1lb_sys_side.sv
module e1lb_sys_side
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  localparam int NSLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lb_mode_e          mode,
  input  logic [NSLOTS-1:0] rem_ts,
  input  logic              sys_in_vld,
  input  logic [SLOT_W-1:0] sys_in_slot,
  input  logic [BYTE_W-1:0] sys_in_data,
  input  logic              line_rx_vld,
  input  logic [SLOT_W-1:0] line_rx_slot,
  input  logic [BYTE_W-1:0] line_rx_data,
  input  logic [BYTE_W-1:0] tx_store_rd,
  input  logic              lnxt_vld,
  input  logic [SLOT_W-1:0] lnxt_slot,
  input  logic [BYTE_W-1:0] lnxt_data,
  output logic              out_vld,
  output logic [SLOT_W-1:0] out_slot,
  output logic [BYTE_W-1:0] out_data
);
  logic              s_vld;
  logic [SLOT_W-1:0] s_slot;
  logic [BYTE_W-1:0] s_data;
  logic              rem_hit;

  assign rem_hit = rem_ts[line_rx_slot] && (line_rx_slot != '0);

  always_comb begin
    if (mode == LB_DIGITAL) begin
      s_vld  = lnxt_vld;
      s_slot = lnxt_slot;
      s_data = lnxt_data;
    end else if (mode == LB_BUS) begin
      s_vld  = sys_in_vld;
      s_slot = sys_in_slot;
      s_data = sys_in_data;
    end else begin
      s_vld  = line_rx_vld;
      s_slot = line_rx_slot;
      s_data = (rem_hit && !owns_sys(mode)) ? tx_store_rd : line_rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_slot <= '0;
      out_data <= '0;
    end else begin
      out_vld  <= s_vld;
      out_slot <= s_slot;
      out_data <= s_data;
    end
  end
endmodule

// File: rtl/e1_loopback_matrix.sv
module e1_loopback_matrix
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter logic [7:0] FAS_WORD  = 8'h9B,
  parameter logic [7:0] NFAS_WORD = 8'hDF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_wdata,
  input  logic              slot_wr,
  input  logic [SLOT_W-1:0] slot_wr_idx,
  input  logic [5:4]        slot_wr_bits,
  input  logic              sys_in_vld,
  input  logic [SLOT_W-1:0] sys_in_slot,
  input  logic [7:0]        sys_in_data,
  input  logic              line_rx_vld,
  input  logic [SLOT_W-1:0] line_rx_slot,
  input  logic [7:0]        line_rx_data,
  output logic              line_tx_vld,
  output logic [SLOT_W-1:0] line_tx_slot,
  output logic [7:0]        line_tx_data,
  output logic              sys_out_vld,
  output logic [SLOT_W-1:0] sys_out_slot,
  output logic [7:0]        sys_out_data
);
  localparam int NSLOTS = 1 << SLOT_W;

  lb_mode_e          mode;
  logic [NSLOTS-1:0] rem_ts;
  logic [NSLOTS-1:0] loc_ts;
  logic [BYTE_W-1:0] rx_store_rd;
  logic [BYTE_W-1:0] tx_store_rd;
  logic              lnxt_vld;
  logic [SLOT_W-1:0] lnxt_slot;
  logic [BYTE_W-1:0] lnxt_data;
  logic              fas_odd;

  e1lb_cfg #(.SLOT_W(SLOT_W)) cfg_i (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .slot_wr, .slot_wr_idx, .slot_wr_bits,
    .mode, .rem_ts, .loc_ts
  );

  // latest received byte per slot, read at the system input slot
  e1lb_store #(.SLOT_W(SLOT_W)) rx_store_i (
    .clk, .rst_n, .wr_en(line_rx_vld), .wr_idx(line_rx_slot), .wr_data(line_rx_data),
    .rd_idx(sys_in_slot), .rd_data(rx_store_rd)
  );

  // latest system input byte per slot, read at the received slot
  e1lb_store #(.SLOT_W(SLOT_W)) tx_store_i (
    .clk, .rst_n, .wr_en(sys_in_vld), .wr_idx(sys_in_slot), .wr_data(sys_in_data),
    .rd_idx(line_rx_slot), .rd_data(tx_store_rd)
  );

  e1lb_line_side #(.SLOT_W(SLOT_W), .FAS_WORD(FAS_WORD), .NFAS_WORD(NFAS_WORD)) line_i (
    .clk, .rst_n, .mode, .loc_ts,
    .sys_in_vld, .sys_in_slot, .sys_in_data,
    .line_rx_vld, .line_rx_slot, .line_rx_data,
    .rx_store_rd,
    .nxt_vld(lnxt_vld), .nxt_slot(lnxt_slot), .nxt_data(lnxt_data),
    .fas_odd,
    .tx_vld(line_tx_vld), .tx_slot(line_tx_slot), .tx_data(line_tx_data)
  );

  e1lb_sys_side #(.SLOT_W(SLOT_W)) sys_i (
    .clk, .rst_n, .mode, .rem_ts,
    .sys_in_vld, .sys_in_slot, .sys_in_data,
    .line_rx_vld, .line_rx_slot, .line_rx_data,
    .tx_store_rd, .lnxt_vld, .lnxt_slot, .lnxt_data,
    .out_vld(sys_out_vld), .out_slot(sys_out_slot), .out_data(sys_out_data)
  );
endmodule

// File: rtl/e1lb_checker.sv
module e1lb_checker
  import e1lb_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter logic [7:0] FAS_WORD  = 8'h9B,
  parameter logic [7:0] NFAS_WORD = 8'hDF
) (
  input logic              clk,
  input logic              rst_n,
  input lb_mode_e          mode,
  input logic              fas_odd,
  input logic              ctl_wr,
  input logic [3:0]        ctl_wdata,
  input logic              sys_in_vld,
  input logic [SLOT_W-1:0] sys_in_slot,
  input logic [7:0]        sys_in_data,
  input logic              line_rx_vld,
  input logic [SLOT_W-1:0] line_rx_slot,
  input logic [7:0]        line_rx_data,
  input logic              line_tx_vld,
  input logic [7:0]        line_tx_data,
  input logic              sys_out_vld,
  input logic [7:0]        sys_out_data
);
  assert_remote_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[2] |=> mode == LB_REMOTE);

  assert_bus_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && (ctl_wdata == 4'b0010) |=> mode == LB_BUS);

  assert_remote_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_REMOTE) && line_rx_vld |=> line_tx_vld && (line_tx_data == $past(line_rx_data)));

  assert_payload_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_PAYLOAD) && line_rx_vld && (line_rx_slot == '0)
      |=> line_tx_data == ($past(fas_odd) ? NFAS_WORD : FAS_WORD));

  assert_bus_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_BUS) && sys_in_vld |=> sys_out_vld && (sys_out_data == $past(sys_in_data)));

  assert_slot0_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_NONE) && sys_in_vld && (sys_in_slot == '0) |=> line_tx_data == $past(sys_in_data));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_in_vld && !line_rx_vld |=> !line_tx_vld && !sys_out_vld);
endmodule

bind e1_loopback_matrix e1lb_checker #(
  .SLOT_W(SLOT_W), .FAS_WORD(FAS_WORD), .NFAS_WORD(NFAS_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .fas_odd(fas_odd),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .sys_in_vld(sys_in_vld), .sys_in_slot(sys_in_slot), .sys_in_data(sys_in_data),
  .line_rx_vld(line_rx_vld), .line_rx_slot(line_rx_slot), .line_rx_data(line_rx_data),
  .line_tx_vld(line_tx_vld), .line_tx_data(line_tx_data),
  .sys_out_vld(sys_out_vld), .sys_out_data(sys_out_data)
);

// File: tb/e1_loopback_matrix_tb.sv
module e1_loopback_matrix_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       slot_wr = 1'b0;
  logic [4:0] slot_wr_idx = '0;
  logic [5:4] slot_wr_bits = '0;
  logic       sys_in_vld = 1'b0;
  logic [4:0] sys_in_slot = '0;
  logic [7:0] sys_in_data = '0;
  logic       line_rx_vld = 1'b0;
  logic [4:0] line_rx_slot = '0;
  logic [7:0] line_rx_data = '0;
  logic       line_tx_vld;
  logic [4:0] line_tx_slot;
  logic [7:0] line_tx_data;
  logic       sys_out_vld;
  logic [4:0] sys_out_slot;
  logic [7:0] sys_out_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  e1_loopback_matrix dut_i (.*);

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic set_glb(input logic [3:0] v);
    @(negedge clk);
    sys_in_vld = 0; line_rx_vld = 0;
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic set_slot(input logic [4:0] idx, input logic [5:4] v);
    @(negedge clk);
    sys_in_vld = 0; line_rx_vld = 0;
    slot_wr = 1; slot_wr_idx = idx; slot_wr_bits = v;
    @(negedge clk);
    slot_wr = 0;
  endtask

  // drive one cycle of both streams; returns just after the capturing edge
  task automatic send(input logic sv, input logic [4:0] ss, input logic [7:0] sd,
                      input logic rv, input logic [4:0] rs, input logic [7:0] rd);
    @(negedge clk);
    sys_in_vld = sv; sys_in_slot = ss; sys_in_data = sd;
    line_rx_vld = rv; line_rx_slot = rs; line_rx_data = rd;
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset();
    check("R1", "line_tx_vld", line_tx_vld, 0);
    check("R1", "sys_out_vld", sys_out_vld, 0);
    check("R1", "line_tx_data", line_tx_data, 0);
    check("R1", "sys_out_data", sys_out_data, 0);
  endtask

  task automatic t_normal();
    send(1, 3, 8'hA5, 1, 3, 8'h3C);
    check("R2", "line_tx_data", line_tx_data, 8'hA5);
    check("R2", "line_tx_slot", line_tx_slot, 3);
    check("R2", "sys_out_data", sys_out_data, 8'h3C);
    check("R2", "sys_out_vld", sys_out_vld, 1);
    send(1, 0, 8'h11, 0, 0, 8'h00);
    check("R2", "line_tx_data slot0", line_tx_data, 8'h11);
    check("R2", "sys_out_vld idle rx", sys_out_vld, 0);
    send(0, 0, 0, 0, 0, 0);
    check("R2", "line_tx_vld idle", line_tx_vld, 0);
  endtask

  task automatic t_slot_loops();
    set_slot(5, 2'b01);
    set_slot(6, 2'b10);
    send(1, 5, 8'h5A, 0, 0, 0);
    check("R9", "line_tx slot5 unflagged local", line_tx_data, 8'h5A);
    send(0, 0, 0, 1, 5, 8'h77);
    check("R9", "sys_out slot5 remote loop", sys_out_data, 8'h5A);
    check("R9", "sys_out_slot", sys_out_slot, 5);
    send(0, 0, 0, 1, 6, 8'hC3);
    check("R9", "sys_out slot6 no remote bit", sys_out_data, 8'hC3);
    send(1, 6, 8'h44, 0, 0, 0);
    check("R9", "line_tx slot6 local loop", line_tx_data, 8'hC3);
    send(1, 7, 8'h5E, 1, 7, 8'hE7);
    check("R2", "line_tx slot7", line_tx_data, 8'h5E);
    check("R2", "sys_out slot7", sys_out_data, 8'hE7);
  endtask

  task automatic t_slot0();
    set_slot(0, 2'b11);
    send(1, 0, 8'h12, 1, 0, 8'h34);
    check("R11", "line_tx slot0", line_tx_data, 8'h12);
    check("R11", "sys_out slot0", sys_out_data, 8'h34);
  endtask

  task automatic t_remote();
    set_glb(4'b0100);
    send(1, 0, 8'h55, 1, 0, 8'h1B);
    check("R4", "line_tx slot0 verbatim", line_tx_data, 8'h1B);
    check("R4", "sys_out keeps rx", sys_out_data, 8'h1B);
    send(1, 6, 8'h44, 1, 6, 8'h99);
    check("R10", "local loop ignored in remote", line_tx_data, 8'h99);
    send(0, 0, 0, 1, 5, 8'h31);
    check("R10", "remote slot loop kept in remote", sys_out_data, 8'h5A);
    check("R4", "line_tx follows rx", line_tx_data, 8'h31);
  endtask

  task automatic t_payload();
    set_glb(4'b0001);
    send(0, 0, 0, 1, 0, 8'h00);
    check("R5", "first slot0 FAS", line_tx_data, 8'h9B);
    send(0, 0, 0, 1, 1, 8'h21);
    check("R5", "slot1 passes", line_tx_data, 8'h21);
    send(0, 0, 0, 1, 0, 8'hFF);
    check("R5", "second slot0 NFAS", line_tx_data, 8'hDF);
    send(0, 0, 0, 1, 0, 8'h00);
    check("R5", "third slot0 FAS", line_tx_data, 8'h9B);
    send(1, 6, 8'h44, 1, 6, 8'hE1);
    check("R10", "local loop ignored in payload", line_tx_data, 8'hE1);
    check("R5", "sys_out keeps rx", sys_out_data, 8'hE1);
  endtask

  task automatic t_digital();
    set_glb(4'b1000);
    send(1, 8, 8'h81, 1, 8, 8'h18);
    check("R6", "sys_out gets tx stream", sys_out_data, 8'h81);
    check("R6", "line_tx still sends", line_tx_data, 8'h81);
    send(1, 6, 8'h44, 0, 0, 0);
    check("R6", "sys_out sees local substitution", sys_out_data, 8'hE1);
    check("R6", "line_tx local substitution", line_tx_data, 8'hE1);
    send(1, 5, 8'h66, 1, 5, 8'h0F);
    check("R10", "remote slot loop ignored in digital", sys_out_data, 8'h66);
  endtask

  task automatic t_bus();
    set_glb(4'b0010);
    send(1, 6, 8'h44, 1, 6, 8'h3C);
    check("R7", "sys_out raw input", sys_out_data, 8'h44);
    check("R7", "line_tx normal with local loop", line_tx_data, 8'hE1);
  endtask

  task automatic t_priority();
    set_glb(4'b1111);
    send(1, 0, 8'h00, 1, 0, 8'h3A);
    check("R8", "all set: remote line_tx", line_tx_data, 8'h3A);
    check("R8", "all set: sys_out rx", sys_out_data, 8'h3A);
    set_glb(4'b1011);
    send(1, 0, 8'h70, 1, 0, 8'h3A);
    check("R8", "payload over digital line_tx", line_tx_data, 8'h9B);
    check("R8", "payload over digital sys_out", sys_out_data, 8'h3A);
    set_glb(4'b1010);
    send(1, 6, 8'h44, 0, 0, 0);
    check("R8", "digital over bus", sys_out_data, 8'h3C);
    set_glb(4'b0000);
    send(1, 9, 8'h90, 1, 9, 8'h09);
    check("R3", "cleared: line_tx", line_tx_data, 8'h90);
    check("R3", "cleared: sys_out", sys_out_data, 8'h09);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_slot_loops();
    t_slot0();
    t_remote();
    t_payload();
    t_digital();
    t_bus();
    t_priority();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      report();
    end
  end
endmodule